// File: doc/BRIEF.md
# Clocked Full-Duplex Serial Port

This block is a synchronous serial port that moves 8-bit frames in both directions at once. It drives a shift clock and a transmit data line, and it samples a receive data line on that same shift clock. A host reaches it through a small register window. The window holds a transmit holding byte, a receive holding byte, a control byte with two enables, and a status byte with three flags. The host clears a flag by reading status while the flag is 1 and then writing a 0 to that bit.

A transfer controller has its own side port. A controller write to the transmit holding byte clears the transmit-empty flag directly. A controller read of the receive holding byte clears the receive-full flag directly. Each flag that rises from 0 to 1 produces a one-cycle interrupt pulse.

A frame starts when the transmitter holds a pending byte. In receive-only mode, frames run one after another. If a frame completes while the previous received byte has not been taken, the overrun flag is set. The port then starts no frame in either direction until the host clears that flag.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset, status reads 0x01 (transmit-empty set, receive-full and overrun clear), control reads 0x00, the shift clock and transmit line are high, and both interrupt outputs are low.
- R2: Control bit 0 enables transmit and bit 1 enables receive. A control write of binary 11 made while exactly one enable is set leaves control unchanged. From the state where both enables are 0, any value is accepted.
- R3: A frame is 8 bits, least significant bit first. The shift clock idles high and toggles only inside a frame, with each half period lasting HALF_DIV clock cycles. The transmit line changes only when the shift clock falls, and the receive line is sampled when the shift clock rises.
- R4: While transmit is enabled, a frame starts on the first clock after transmit-empty is 0, overrun is 0 and no frame is active. In that same cycle the holding byte moves into the shifter and transmit-empty returns to 1. With only receive enabled, frames start whenever overrun is 0, and the transmit line stays high.
- R5: When a frame ends with receive enabled and receive-full at 0, the received byte is placed in the receive holding register and receive-full becomes 1 in that cycle.
- R6: When a frame ends with receive enabled and receive-full already 1, overrun becomes 1 and the receive holding byte is kept. While overrun is 1, the shift clock stays high.
- R7: Each of the transmit and receive interrupt outputs pulses high for one cycle, in the cycle its flag rises from 0 to 1.
- R8: Status bit 0 is transmit-empty, bit 1 is receive-full and bit 2 is overrun. Writing 0 to a status bit clears that flag only if a status read since the flag last rose returned it as 1. Otherwise the write leaves the flag unchanged, and writing 1 has no effect.
- R9: A controller-side write loads the transmit holding byte and clears transmit-empty. A controller-side read returns the receive holding byte and clears receive-full.
- R10: If the next transmit byte is pending when a frame ends, the next frame's first shift-clock fall comes on the following clock cycle.
- R11: The host register address map is: address 0 is transmit holding (read and write), 1 is receive holding (read), 2 is control, and 3 is status. A host write to address 0 changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Host register select |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (arms flag clears when reading status) |
| reg_wdata | input | DATA_W | Host write data |
| reg_rdata | output | DATA_W | Host read data, combinational from the register select |
| xfer_wr | input | 1 | Controller-side write of the transmit holding byte |
| xfer_wdata | input | DATA_W | Controller-side write data |
| xfer_rd | input | 1 | Controller-side read strobe of the receive holding byte |
| xfer_rdata | output | DATA_W | Receive holding byte for the controller side |
| irq_tx | output | 1 | Transmit-empty rise pulse |
| irq_rx | output | 1 | Receive-full rise pulse |
| sck | output | 1 | Shift clock, idles high |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |

## Verification
Register writes take effect at the clock edge that samples the strobe, and reads return data combinationally, so the bench samples one negative edge after each access. A flag write enables a frame one edge after that, at the edge where the shift clock falls, transmit-empty is set again and the transmit pulse fires. The frame ends 2·8·HALF_DIV cycles later with the receive flag and pulse. The next frame's shift-clock fall follows one edge after that, and the bench checks for it at exactly the next negative edge. Serial data is scored on shift-clock rises, when the transmit line has been stable for half a bit period. Overrun and idle checks hold the line over windows longer than a full frame.

// File: rtl/ssx_pkg.sv
package ssx_pkg;

    typedef enum logic [1:0] {
        SEL_TXHOLD = 2'd0,
        SEL_RXHOLD = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_STAT   = 2'd3
    } reg_sel_e;

    localparam int NFLAG    = 3;
    localparam int F_TXE    = 0;
    localparam int F_RXF    = 1;
    localparam int F_OVR    = 2;
    localparam int CTL_TXEN = 0;
    localparam int CTL_RXEN = 1;

endpackage

// File: rtl/ssx_sclk_gen.sv
module ssx_sclk_gen #(
    parameter int HALF_DIV = 4,
    parameter int BITS     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic sck,
    output logic busy,
    output logic rise_evt,
    output logic fall_evt,
    output logic done
);
    localparam int CW    = $clog2(HALF_DIV + 1);
    localparam int HW    = $clog2(2 * BITS);
    localparam int LASTH = 2 * BITS - 1;

    typedef struct packed {
        logic          busy;
        logic          sck;
        logic [CW-1:0] cnt;
        logic [HW-1:0] half;
    } gen_st_t;

    gen_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        rise_evt = 1'b0;
        fall_evt = 1'b0;
        done     = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.sck  = 1'b0;
                st_d.cnt  = '0;
                st_d.half = '0;
            end
        end else if (st_q.cnt == CW'(HALF_DIV - 1)) begin
            st_d.cnt = '0;
            if (st_q.half == HW'(LASTH)) begin
                st_d.busy = 1'b0;
                done      = 1'b1;
            end else begin
                st_d.half = st_q.half + HW'(1);
                st_d.sck  = ~st_q.sck;
                rise_evt  = ~st_q.sck;
                fall_evt  = st_q.sck;
            end
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, sck: 1'b1, cnt: '0, half: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sck  = st_q.sck;
    assign busy = st_q.busy;

endmodule

// File: rtl/ssx_shift.sv
module ssx_shift #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [BITS-1:0] load_data,
    input  logic            fall_evt,
    input  logic            rise_evt,
    input  logic            done,
    input  logic            rxd,
    output logic            txd,
    output logic [BITS-1:0] rx_byte
);
    typedef struct packed {
        logic [BITS-1:0] tx_sh;
        logic [BITS-1:0] rx_sh;
        logic            txd;
    } sh_st_t;

    sh_st_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.tx_sh = load_data;
            sh_d.txd   = load_data[0];
        end else if (fall_evt) begin
            sh_d.tx_sh = sh_q.tx_sh >> 1;
            sh_d.txd   = sh_q.tx_sh[1];
        end else if (done) begin
            sh_d.txd = 1'b1;
        end
        if (rise_evt) begin
            sh_d.rx_sh = {rxd, sh_q.rx_sh[BITS-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '{tx_sh: '1, rx_sh: '0, txd: 1'b1};
        end else begin
            sh_q <= sh_d;
        end
    end

    assign txd     = sh_q.txd;
    assign rx_byte = sh_q.rx_sh;

endmodule

// File: rtl/ssx_ctl.sv
module ssx_ctl
    import ssx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       host_addr,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [DW-1:0]    host_wdata,
    input  logic             xfer_wr,
    input  logic [DW-1:0]    xfer_wdata,
    input  logic             xfer_rd,
    input  logic             busy,
    input  logic             done,
    input  logic [DW-1:0]    rx_byte,
    output logic             start,
    output logic [DW-1:0]    load_data,
    output logic [DW-1:0]    tdr,
    output logic [DW-1:0]    rdr,
    output logic [1:0]       ctl,
    output logic [NFLAG-1:0] flags,
    output logic             irq_tx,
    output logic             irq_rx
);
    typedef struct packed {
        logic [DW-1:0]    tdr;
        logic [DW-1:0]    rdr;
        logic             tx_en;
        logic             rx_en;
        logic [NFLAG-1:0] flag;
        logic [NFLAG-1:0] arm;
        logic             irq_tx;
        logic             irq_rx;
    } ctl_st_t;

    ctl_st_t  c_d, c_q;
    reg_sel_e sel;

    always_comb begin
        sel    = reg_sel_e'(host_addr);
        c_d    = c_q;
        start  = 1'b0;

        // a status read arms every flag it returns as 1
        if (host_rd && sel == SEL_STAT) begin
            c_d.arm = c_q.arm | c_q.flag;
        end

        if (host_wr) begin
            case (sel)
                SEL_TXHOLD: c_d.tdr = host_wdata;
                SEL_CTRL: begin
                    // joint enable only allowed from the fully idle state
                    if (!(host_wdata[1:0] == 2'b11 && (c_q.tx_en ^ c_q.rx_en))) begin
                        c_d.tx_en = host_wdata[CTL_TXEN];
                        c_d.rx_en = host_wdata[CTL_RXEN];
                    end
                end
                SEL_STAT: begin
                    for (int i = 0; i < NFLAG; i++) begin
                        if (!host_wdata[i] && c_q.arm[i] && c_q.flag[i]) begin
                            c_d.flag[i] = 1'b0;
                            c_d.arm[i]  = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end

        if (xfer_rd) begin
            c_d.flag[F_RXF] = 1'b0;
            c_d.arm[F_RXF]  = 1'b0;
        end

        start = !busy && !c_q.flag[F_OVR] &&
                ((c_q.tx_en && !c_q.flag[F_TXE]) || (c_q.rx_en && !c_q.tx_en));
        if (start && c_q.tx_en) begin
            c_d.flag[F_TXE] = 1'b1;
        end

        if (xfer_wr) begin
            c_d.tdr         = xfer_wdata;
            c_d.flag[F_TXE] = 1'b0;
            c_d.arm[F_TXE]  = 1'b0;
        end

        if (done && c_q.rx_en) begin
            if (c_d.flag[F_RXF]) begin
                c_d.flag[F_OVR] = 1'b1;
            end else begin
                c_d.rdr         = rx_byte;
                c_d.flag[F_RXF] = 1'b1;
            end
        end

        c_d.irq_tx = c_d.flag[F_TXE] & ~c_q.flag[F_TXE];
        c_d.irq_rx = c_d.flag[F_RXF] & ~c_q.flag[F_RXF];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{tdr: '0, rdr: '0, tx_en: 1'b0, rx_en: 1'b0,
                     flag: NFLAG'(1) << F_TXE, arm: '0, irq_tx: 1'b0, irq_rx: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign load_data = c_q.tx_en ? c_q.tdr : '1;
    assign tdr       = c_q.tdr;
    assign rdr       = c_q.rdr;
    assign ctl       = {c_q.rx_en, c_q.tx_en};
    assign flags     = c_q.flag;
    assign irq_tx    = c_q.irq_tx;
    assign irq_rx    = c_q.irq_rx;

endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
    import ssx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              xfer_wr,
    input  logic [DATA_W-1:0] xfer_wdata,
    input  logic              xfer_rd,
    output logic [DATA_W-1:0] xfer_rdata,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              sck,
    output logic              txd,
    input  logic              rxd
);
    logic              start_w, busy_w, rise_w, fall_w, done_w;
    logic [DATA_W-1:0] load_w, rxbyte_w, tdr_w, rdr_w;
    logic [1:0]        ctl_w;
    logic [NFLAG-1:0]  flag_w;

    ssx_ctl #(.DW(DATA_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (reg_addr),
        .host_wr    (reg_wr),
        .host_rd    (reg_rd),
        .host_wdata (reg_wdata),
        .xfer_wr    (xfer_wr),
        .xfer_wdata (xfer_wdata),
        .xfer_rd    (xfer_rd),
        .busy       (busy_w),
        .done       (done_w),
        .rx_byte    (rxbyte_w),
        .start      (start_w),
        .load_data  (load_w),
        .tdr        (tdr_w),
        .rdr        (rdr_w),
        .ctl        (ctl_w),
        .flags      (flag_w),
        .irq_tx     (irq_tx),
        .irq_rx     (irq_rx)
    );

    ssx_sclk_gen #(.HALF_DIV(HALF_DIV), .BITS(DATA_W)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_w),
        .sck      (sck),
        .busy     (busy_w),
        .rise_evt (rise_w),
        .fall_evt (fall_w),
        .done     (done_w)
    );

    ssx_shift #(.BITS(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start_w),
        .load_data (load_w),
        .fall_evt  (fall_w),
        .rise_evt  (rise_w),
        .done      (done_w),
        .rxd       (rxd),
        .txd       (txd),
        .rx_byte   (rxbyte_w)
    );

    always_comb begin
        case (reg_sel_e'(reg_addr))
            SEL_TXHOLD: reg_rdata = tdr_w;
            SEL_RXHOLD: reg_rdata = rdr_w;
            SEL_CTRL:   reg_rdata = DATA_W'(ctl_w);
            default:    reg_rdata = DATA_W'(flag_w);
        endcase
    end

    assign xfer_rdata = rdr_w;

endmodule

// File: rtl/ssx_checker.sv
module ssx_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sck,
    input logic          txd,
    input logic          irq_tx,
    input logic          irq_rx,
    input logic          reg_wr,
    input logic [1:0]    reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic [1:0]    ctl,
    input logic [2:0]    flags,
    input logic [DW-1:0] rdr
);
    p_txd_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> $stable(txd));

    p_ctl_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2 && reg_wdata[1:0] == 2'b11 && (^ctl)) |=> $stable(ctl));

    p_irqtx_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |=> !irq_tx);

    p_irqrx_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |=> !irq_rx);

    p_irqrx_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> flags[1]);

    p_ovr_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[2]) |-> $stable(rdr));

    p_ovr_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[2] && sck) |=> sck);

endmodule

bind sync_serial_xcvr ssx_checker #(.DW(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck       (sck),
    .txd       (txd),
    .irq_tx    (irq_tx),
    .irq_rx    (irq_rx),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ctl       (ctl_w),
    .flags     (flag_w),
    .rdr       (rdr_w)
);

// File: tb/sim_sync_serial_xcvr.sv
module sim_sync_serial_xcvr;
    localparam int DW = 8;
    localparam int HD = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [DW-1:0] reg_wdata = '0, reg_rdata;
    logic          xfer_wr = 1'b0, xfer_rd = 1'b0;
    logic [DW-1:0] xfer_wdata = '0, xfer_rdata;
    logic          irq_tx, irq_rx, sck, txd;
    logic          rxd = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] exp_tx_q[$];
    logic [7:0] rx_src_q[$];
    logic       mon_en = 1'b0;
    int         mon_bits = 0;
    logic [7:0] mon_sh = '0;
    int         rx_idx = 0;
    logic [7:0] rx_cur = '0;

    always #4 clk = ~clk;

    sync_serial_xcvr #(.DATA_W(DW), .HALF_DIV(HD)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_wr(xfer_wr),
        .xfer_wdata(xfer_wdata), .xfer_rd(xfer_rd), .xfer_rdata(xfer_rdata),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .sck(sck), .txd(txd), .rxd(rxd)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic xfer_write(input logic [7:0] d);
        @(negedge clk);
        xfer_wdata = d; xfer_wr = 1'b1;
        @(negedge clk);
        xfer_wr = 1'b0;
    endtask

    task automatic xfer_read(output logic [7:0] d);
        @(negedge clk);
        xfer_rd = 1'b1;
        #1 d = xfer_rdata;
        @(negedge clk);
        xfer_rd = 1'b0;
    endtask

    task automatic wait_irq_tx(input string req);
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (irq_tx) break;
        end
        check(req, irq_tx, 1);
    endtask

    task automatic wait_irq_rx(input string req);
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (irq_rx) break;
        end
        check(req, irq_rx, 1);
    endtask

    // monitor: scores each transmitted byte against the expected queue (R3)
    always @(posedge sck) begin
        if (!mon_en) begin
            mon_bits = 0;
        end else begin
            mon_sh = {txd, mon_sh[7:1]};
            mon_bits++;
            if (mon_bits == 8) begin
                mon_bits = 0;
                if (exp_tx_q.size() == 0) check("R3 unexpected tx frame", 1, 0);
                else check("R3 tx byte lsb first", mon_sh, exp_tx_q.pop_front());
            end
        end
    end

    // peripheral side: presents receive bits on each shift-clock fall
    always @(negedge sck) begin
        if (rx_idx == 0) rx_cur = (rx_src_q.size() != 0) ? rx_src_q.pop_front() : 8'h00;
        rxd    = rx_cur[rx_idx];
        rx_idx = (rx_idx + 1) % 8;
    end

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R3 watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic       bad;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 sck idle", sck, 1);
        check("R1 txd idle", txd, 1);
        check("R1 irqs low", {irq_tx, irq_rx}, 0);
        reg_read(2'd2, v); check("R1 control", v, 8'h00);

        // R11 tx holding write, R8 clear without a prior read
        reg_write(2'd0, 8'hA5);
        reg_write(2'd3, 8'h00);
        reg_read(2'd3, v); check("R8 unarmed clear ignored / R1 status", v, 8'h01);
        reg_read(2'd0, v); check("R11 tx holding readback", v, 8'hA5);

        // R2 enable rule
        reg_write(2'd2, 8'h01);
        reg_write(2'd2, 8'h03);
        reg_read(2'd2, v); check("R2 joint enable refused", v, 8'h01);
        reg_write(2'd2, 8'h00);
        reg_write(2'd2, 8'h03);
        reg_read(2'd2, v); check("R2 joint enable from idle", v, 8'h03);

        bad = 1'b0;
        repeat (40) begin @(negedge clk); if (!sck) bad = 1'b1; end
        check("R3 sck idle without data", bad, 0);

        // first full-duplex frame
        mon_en = 1'b1;
        exp_tx_q.push_back(8'hA5);
        rx_src_q.push_back(8'h3C);
        reg_write(2'd3, 8'h06);
        wait_irq_tx("R4 frame start sets tx-empty");
        check("R4 sck falls at start", sck, 0);
        @(negedge clk); check("R7 tx pulse one cycle", irq_tx, 0);
        wait_irq_rx("R5 receive-full rises");
        @(negedge clk); check("R7 rx pulse one cycle", irq_rx, 0);
        reg_read(2'd1, v); check("R5 receive holding", v, 8'h3C);
        reg_read(2'd3, v); check("R5 status after frame", v, 8'h03);
        reg_write(2'd3, 8'h05);
        reg_read(2'd3, v); check("R8 armed clear", v, 8'h01);

        // back-to-back frames through the controller side
        exp_tx_q.push_back(8'h5A); exp_tx_q.push_back(8'hC3);
        rx_src_q.push_back(8'h11); rx_src_q.push_back(8'h22);
        xfer_write(8'h5A);
        wait_irq_tx("R9 controller write starts frame");
        xfer_write(8'hC3);
        wait_irq_rx("R5 first of pair");
        @(negedge clk); check("R10 next frame one cycle later", sck, 0);
        xfer_read(v); check("R9 controller read data", v, 8'h11);
        wait_irq_rx("R9 controller read cleared receive-full");
        xfer_read(v); check("R9 controller read second", v, 8'h22);
        reg_read(2'd3, v); check("R9 flags after pair", v, 8'h01);

        // overrun
        exp_tx_q.push_back(8'h77); exp_tx_q.push_back(8'h88); exp_tx_q.push_back(8'h44);
        rx_src_q.push_back(8'h99); rx_src_q.push_back(8'hAA); rx_src_q.push_back(8'hBB);
        xfer_write(8'h77);
        wait_irq_tx("R4 start for overrun case");
        xfer_write(8'h88);
        wait_irq_rx("R5 first byte before overrun");
        repeat (60) @(negedge clk);
        reg_read(2'd3, v); check("R6 overrun flagged", v, 8'h07);
        reg_read(2'd1, v); check("R6 old byte kept", v, 8'h99);
        xfer_write(8'h44);
        bad = 1'b0;
        repeat (60) begin @(negedge clk); if (!sck) bad = 1'b1; end
        check("R6 frozen while overrun", bad, 0);
        reg_read(2'd3, v); check("R6 status while frozen", v, 8'h06);
        reg_write(2'd3, 8'h01);
        wait_irq_rx("R6 resumes after clear");
        xfer_read(v); check("R6 byte after resume", v, 8'hBB);
        reg_read(2'd3, v); check("R8 overrun cleared", v, 8'h01);

        // receive-only
        repeat (5) @(negedge clk);
        mon_en = 1'b0;
        rx_src_q.push_back(8'hE1);
        reg_write(2'd2, 8'h00);
        reg_write(2'd2, 8'h02);
        bad = 1'b0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (!txd) bad = 1'b1;
            if (irq_rx) break;
        end
        check("R4 receive-only frame", irq_rx, 1);
        check("R4 txd high in receive-only", bad, 0);
        xfer_read(v); check("R4 receive-only data", v, 8'hE1);
        reg_write(2'd2, 8'h00);
        repeat (60) @(negedge clk);
        reg_read(2'd3, v); check("R5 no capture when disabled", v, 8'h01);
        check("R3 all tx frames seen", exp_tx_q.size(), 0);

        report();
        $finish;
    end

endmodule